// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a byte-wide peripheral bus with select, enable, write, a 12-bit address and 8-bit data. It holds a per-pin direction register and an output data register, drives the pin outputs and output-enables, and samples the input pins through a two-stage synchronizer. The synchronized pin values are also brought out so that a separate interrupt-detection block can use them.

Data accesses do not use a single address. Address bits [9:2] of any access inside the 1 KiB data window act as a per-bit mask. A read returns only the selected bits and a write changes only the selected bits, so software can touch one pin, or any subset of pins, with one access and without read-modify-write. Every transfer completes with no wait states.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is high and after it is released, every pin is an input (pin_oe = 0x00), the output data register is 0x00 (pin_out = 0x00) and prdata is 0x00.
- R2: The direction register is at offset 0x400. Bit n = 1 makes pin n an output and 0 makes it an input. A write takes effect on pin_oe in the cycle after the access phase, and a read returns the stored value.
- R3: Offsets with paddr[11:10] = 2'b00 form the data window, and paddr[9:2] is the access mask. A write at offset 0x3FC (all mask bits set) loads every output-pin bit from pwdata.
- R4: A data write at offset (1 << (n+2)) changes at most pin_out bit n. All other bits keep their value.
- R5: A data write does not change the output data bits of pins that are inputs at the time of the write. Those bits keep their old value after the pin is later switched to output.
- R6: A data read returns 0 in every bit whose mask bit (paddr[n+2]) is 0.
- R7: A data read returns, in each selected bit, the synchronized pin value for an input pin and the driven output value for an output pin.
- R8: Every offset outside the data window other than 0x400 is unmapped. This includes 0x404 to 0x41C, which the interrupt block decodes. Reads of unmapped offsets return 0x00, and writes to them change neither register.
- R9: pin_sync equals pin_in delayed by exactly two clock cycles.
- R10: A read has no wait states. prdata holds the result during the access phase that follows the setup phase (psel=1, penable=0), and is 0x00 at other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output-enables, 1 = drive |
| pin_sync | output | 8 | Synchronized pin values for interrupt detection |

## Verification
The bench writes data while pins are still inputs and then turns them into outputs. A design that stores the discarded bits would show them on pin_out. It writes single-pin offsets and narrow masks, which catch a design that ignores the mask or takes the mask from the wrong address bits. It reads back a mix of input and output pins with pin_in set against the driven values, which shows whether output pins report the pad or the register. It also checks offsets just past the direction register and in the upper address range, to expose decoding that aliases those offsets onto the data window, and it counts the synchronizer delay cycle by cycle.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;

  // Which register a bus address selects
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2
  } region_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mport_pkg::*;
#(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [11:0] DIR_OFF = 12'h400
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [NPIN-1:0]   sel_mask
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = NPIN + 1;
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFF >> 2);

  logic in_window;
  logic is_dir;

  // The data window is every address whose bits above the mask field are zero
  assign in_window = (addr[ADDR_W-1:MASK_HI+1] == '0);
  assign is_dir    = (addr[ADDR_W-1:2] == DIR_WORD);
  assign sel_mask  = addr[MASK_HI:MASK_LO];

  always_comb begin
    if (in_window)   region = RGN_DATA;
    else if (is_dir) region = RGN_DIR;
    else             region = RGN_NONE;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[p]};
    end
    assign sync_out[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_dir,
  input  logic            wr_data,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] wmask,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] dout_q
);
  for (genvar p = 0; p < NPIN; p++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[p]  <= 1'b0;
        dout_q[p] <= 1'b0;
      end else begin
        if (wr_dir) dir_q[p] <= wdata[p];
        // A bit is updated only when selected and currently an output
        if (wr_data && wmask[p] && dir_q[p]) dout_q[p] <= wdata[p];
      end
    end
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mport_pkg::*;
#(
  parameter int unsigned NPIN       = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [11:0] DIR_OFF    = 12'h400,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NPIN-1:0]   pwdata,
  output logic [NPIN-1:0]   prdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_sync
);
  region_e         region;
  logic [NPIN-1:0] sel_mask;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] dout_q;
  logic [NPIN-1:0] synced;
  logic            acc_wr;
  logic            setup_rd;
  logic [NPIN-1:0] rd_value;

  gpio_addr_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_dec (
    .addr     (paddr),
    .region   (region),
    .sel_mask (sel_mask)
  );

  gpio_in_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGE)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (synced)
  );

  assign acc_wr   = psel && penable && pwrite;
  assign setup_rd = psel && !penable && !pwrite;

  gpio_out_regs #(.NPIN(NPIN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_dir  (acc_wr && (region == RGN_DIR)),
    .wr_data (acc_wr && (region == RGN_DATA)),
    .wdata   (pwdata),
    .wmask   (sel_mask),
    .dir_q   (dir_q),
    .dout_q  (dout_q)
  );

  // Read mux: output pins report the driven value, inputs the synchronized pad
  always_comb begin
    unique case (region)
      RGN_DATA: rd_value = sel_mask & ((dir_q & dout_q) | (~dir_q & synced));
      RGN_DIR:  rd_value = dir_q;
      default:  rd_value = '0;
    endcase
  end

  // Captured in setup so that it is valid for the whole access phase
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (setup_rd) prdata <= rd_value;
    else               prdata <= '0;
  end

  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;
  assign pin_sync = synced;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [11:0] DIR_OFF = 12'h400
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [NPIN-1:0]   pwdata,
  input logic [NPIN-1:0]   prdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_sync
);
  localparam logic [ADDR_W-3:0] DIR_WORD = (ADDR_W-2)'(DIR_OFF >> 2);

  logic       wr_acc;
  logic       data_win;
  logic [1:0] age;

  assign wr_acc   = psel && penable && pwrite;
  assign data_win = (paddr[ADDR_W-1:NPIN+2] == '0);

  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && prdata == '0));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr[ADDR_W-1:2] == DIR_WORD) |=> pin_oe == $past(pwdata));

  assert_mask_limits_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && data_win) |=> ((pin_out ^ $past(pin_out)) & ~$past(paddr[NPIN+1:2])) == '0);

  assert_input_discard_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && data_win) |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> pin_sync == $past(pin_in, 2));

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !(psel && !penable && !pwrite) |=> prdata == '0);
endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .NPIN(NPIN), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)
) u_chk (.*);

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_sync;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_masked_port u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_sync(pin_sync)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R1 prdata in reset", prdata, 8'h00);
    @(negedge clk); rst = 0;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    bus_rd(12'h400, r); chk("R1 dir read", r, 8'h00);
    bus_rd(12'h3FC, r); chk("R1 data read", r, 8'h00);
  endtask

  task automatic t_discard;
    bus_wr(12'h3FC, 8'hFF);
    chk("R5 write to inputs", pin_out, 8'h00);
    bus_wr(12'h400, 8'hFF);
    chk("R2 pin_oe after dir write", pin_oe, 8'hFF);
    chk("R5 not retained", pin_out, 8'h00);
  endtask

  task automatic t_full_write;
    logic [7:0] r;
    bus_wr(12'h3FC, 8'h3C);
    chk("R3 full mask write", pin_out, 8'h3C);
    bus_rd(12'h400, r); chk("R2 dir readback", r, 8'hFF);
  endtask

  task automatic t_single_pin;
    bus_wr(12'h004, 8'hFF);
    chk("R4 pin0 set", pin_out, 8'h3D);
    bus_wr(12'h020, 8'h00);
    chk("R4 pin3 clear", pin_out, 8'h35);
  endtask

  task automatic t_partial_dir;
    bus_wr(12'h400, 8'h0F);
    chk("R2 partial dir", pin_oe, 8'h0F);
    bus_wr(12'h3FC, 8'hFF);
    chk("R5 upper bits kept", pin_out, 8'h3F);
  endtask

  task automatic t_masked_read;
    logic [7:0] r;
    @(negedge clk); pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    bus_rd(12'h3FC, r); chk("R7 mixed read", r, 8'hAF);
    bus_rd(12'h0F0, r); chk("R6 narrow mask", r, 8'h2C);
    bus_rd(12'h200, r); chk("R6 pin7 only", r, 8'h80);
    bus_rd(12'h000, r); chk("R6 empty mask", r, 8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] r;
    bus_rd(12'h404, r); chk("R8 read 0x404", r, 8'h00);
    bus_rd(12'h41C, r); chk("R8 read 0x41C", r, 8'h00);
    bus_rd(12'hBFC, r); chk("R8 read 0xBFC", r, 8'h00);
    bus_wr(12'h404, 8'hFF);
    bus_wr(12'h800, 8'h00);
    bus_wr(12'hFFC, 8'h00);
    bus_rd(12'h400, r); chk("R8 dir untouched", r, 8'h0F);
    chk("R8 data untouched", pin_out, 8'h3F);
  endtask

  task automatic t_sync;
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); chk("R9 one cycle old", pin_sync, 8'hA5);
    @(negedge clk); chk("R9 two cycles new", pin_sync, 8'h5A);
  endtask

  task automatic t_rdata_phase;
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 12'h400;
    @(negedge clk); penable = 1; chk("R10 access phase data", prdata, 8'h0F);
    @(negedge clk); psel = 0; penable = 0; chk("R10 idle zero", prdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_discard();
    t_full_write();
    t_single_pin();
    t_partial_dir();
    t_masked_read();
    t_unmapped();
    t_sync();
    t_rdata_phase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule